// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block watches a calendar that is kept elsewhere and raises an alarm when the time reaches a programmed point. It has six compare registers, one each for second, minute, hour, weekday, day of month and month. Each register is one byte: a BCD compare value in the low seven bits and a compare-enable in the top bit. Only fields whose enable is set are compared, so software can match any subset, for example "every day at 07:30:00" or "any time in December".

The calendar counters drive the six current-time inputs in BCD and pulse a seconds-advance strobe in the cycle in which the new time is present. The comparison runs only on that strobe. When at least one field is enabled and every enabled field equals its counter, a sticky alarm flag is set. The flag, together with an alarm interrupt enable, sits in a control register. The interrupt output is high while both are set. Software clears the flag by writing zero to its bit. Year is not compared.

Registers are reached through a simple write port (enable, address, data) and a combinational read port that shares the same address.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, all six compare registers and the control register read 0x00, and `irq_alarm` is low.
- R2: A write to addresses 8 to 13 (second, minute, hour, weekday, day, month, in that order) stores the full byte, which reads back unchanged at the same address.
- R3: A field whose bit 7 is 0 takes no part in the match, whatever its low bits hold. When no field has bit 7 set, the strobe never sets the flag. This includes a compare register written as 0x00.
- R4: When `sec_tick` is high and every enabled field's bits 6:0 equal the matching current-time input, the flag is set at that clock edge. It then reads as bit 0 of the control register at address 14. Month is compared on the counter's 1 to 12 BCD scale.
- R5: No compare takes place without `sec_tick`. Matching time inputs with the strobe low leave the flag clear.
- R6: A mismatch in any single enabled field keeps the flag clear on a strobe.
- R7: The flag is sticky. It stays set across later strobes, whether they match or not. Writing 1 to bit 0 of address 14 neither sets nor clears it.
- R8: Writing the control register with bit 0 at 0 clears the flag on that edge.
- R9: Bit 3 of address 14 is the alarm interrupt enable. It is written and read back directly. `irq_alarm` is high exactly while the flag and the enable are both 1. The other control bits read as 0.
- R10: When a clearing control write and a matching strobe fall in the same cycle, the flag ends up set.
- R11: Writes to addresses outside 8 to 14 change nothing, and those addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours, BCD |
| cur_wday | input | 7 | Current weekday, BCD |
| cur_mday | input | 7 | Current day of month, BCD |
| cur_mon | input | 7 | Current month 1 to 12, BCD |
| sec_tick | input | 1 | High for one cycle when the counters hold a new second |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_alarm | output | 1 | Alarm interrupt, flag AND enable |

## Verification
A matching seconds strobe and a software write of zero to the flag bit can land on the same edge: the set path and the clear path then contend for one flip-flop. The bench provokes this by driving a matching time with `sec_tick` high while a control write of 0x08 is active in the same cycle. It judges the outcome by reading address 14 as 0x09 with `irq_alarm` high. It also checks the reverse case, a clearing write with no strobe, which must leave 0x08.

// File: rtl/alarm_pkg.sv
// Package: shared constants and the field index type for the alarm unit.
// Assumes the six fields are ordered second first, month last, matching
// their register offsets.
package alarm_pkg;

    localparam int FIELD_CNT = 6;
    localparam int BCD_W     = 7;

    typedef enum logic [2:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_WDAY = 3'd3,
        FLD_MDAY = 3'd4,
        FLD_MON  = 3'd5
    } field_e;

endpackage

// File: rtl/alarm_regfile.sv
// Module: alarm_regfile
// Holds the six compare registers (BCD value plus enable per byte) and
// decodes the register address for them. Each field's address is
// BASE_ADDR + field index. Assumes writes are single-cycle strobes.
module alarm_regfile #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int FIELDS    = alarm_pkg::FIELD_CNT,
    parameter int BASE_ADDR = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [FIELDS-1:0][DATA_W-1:0]  regs,
    output logic [FIELDS-1:0]              sel
);

    genvar gi;
    generate
        for (gi = 0; gi < FIELDS; gi++) begin : g_field
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR + gi);

            // Address decode for this field's register.
            assign sel[gi] = (addr == MY_ADDR);

            // Storage of this field's compare byte.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[gi] <= '0;
                end else if (wr_en && sel[gi]) begin
                    regs[gi] <= wdata;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/alarm_cmp.sv
// Module: alarm_cmp
// Compares each enabled field against the live BCD counter. A field with
// its enable bit low counts as a hit. Reports a match only on the strobe
// and only if at least one field is enabled. Purely combinational.
module alarm_cmp #(
    parameter int DATA_W = 8,
    parameter int FIELDS = alarm_pkg::FIELD_CNT
) (
    input  logic [FIELDS-1:0][DATA_W-1:0]  regs,
    input  logic [FIELDS-1:0][DATA_W-2:0]  now,
    input  logic                           tick,
    output logic                           any_en,
    output logic                           match
);

    localparam int EN_POS = DATA_W - 1;
    localparam int VAL_W  = DATA_W - 1;

    logic [FIELDS-1:0] en_vec;
    logic [FIELDS-1:0] hit_vec;

    genvar gi;
    generate
        for (gi = 0; gi < FIELDS; gi++) begin : g_cmp
            // Per-field enable and equality; disabled fields always hit.
            assign en_vec[gi]  = regs[gi][EN_POS];
            assign hit_vec[gi] = !en_vec[gi] || (regs[gi][VAL_W-1:0] == now[gi]);
        end
    endgenerate

    // Combine per-field results into the strobe-qualified match.
    always_comb begin
        any_en = |en_vec;
        match  = tick && any_en && (&hit_vec);
    end

endmodule

// File: rtl/alarm_flag_ctl.sv
// Module: alarm_flag_ctl
// Keeps the sticky alarm flag and the interrupt enable. Software can only
// clear the flag; a compare match in the same cycle wins over the clear.
module alarm_flag_ctl #(
    parameter int DATA_W   = 8,
    parameter int FLAG_POS = 0,
    parameter int IE_POS   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_req,
    output logic              flag,
    output logic              ie,
    output logic              irq
);

    // Flag: set by match, cleared by a zero write, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_req) begin
            flag <= 1'b1;
        end else if (ctrl_wr && !wdata[FLAG_POS]) begin
            flag <= 1'b0;
        end
    end

    // Interrupt enable: plain read/write bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie <= 1'b0;
        end else if (ctrl_wr) begin
            ie <= wdata[IE_POS];
        end
    end

    // Interrupt output gated by the enable.
    assign irq = flag && ie;

endmodule

// File: rtl/alarm_match_unit.sv
// Module: alarm_match_unit (top)
// Masked BCD alarm comparator: six compare registers, a control register
// holding flag and interrupt enable, and a combinational read port.
// Assumes the time inputs already show the new second when sec_tick is high.
module alarm_match_unit #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int BASE_ADDR = 8,
    parameter int CTRL_ADDR = 14,
    parameter int FLAG_POS  = 0,
    parameter int IE_POS    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-2:0] cur_sec,
    input  logic [DATA_W-2:0] cur_min,
    input  logic [DATA_W-2:0] cur_hour,
    input  logic [DATA_W-2:0] cur_wday,
    input  logic [DATA_W-2:0] cur_mday,
    input  logic [DATA_W-2:0] cur_mon,
    input  logic              sec_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_alarm
);

    import alarm_pkg::*;

    localparam int VAL_W = DATA_W - 1;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic [FIELD_CNT-1:0][DATA_W-1:0] cmp_regs;
    logic [FIELD_CNT-1:0]             cmp_sel;
    logic [FIELD_CNT-1:0][VAL_W-1:0]  now_vec;
    logic                             any_en;
    logic                             set_req;
    logic                             ctrl_sel;
    logic                             ctrl_wr;
    logic                             flag;
    logic                             ie;
    logic                             irq;

    // Gather the live counter fields in register order.
    always_comb begin
        now_vec[FLD_SEC]  = cur_sec;
        now_vec[FLD_MIN]  = cur_min;
        now_vec[FLD_HOUR] = cur_hour;
        now_vec[FLD_WDAY] = cur_wday;
        now_vec[FLD_MDAY] = cur_mday;
        now_vec[FLD_MON]  = cur_mon;
    end

    assign ctrl_sel = (reg_addr == CTRL_A);
    assign ctrl_wr  = reg_wr && ctrl_sel;

    alarm_regfile #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .FIELDS    (FIELD_CNT),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .regs  (cmp_regs),
        .sel   (cmp_sel)
    );

    alarm_cmp #(
        .DATA_W (DATA_W),
        .FIELDS (FIELD_CNT)
    ) u_cmp (
        .regs   (cmp_regs),
        .now    (now_vec),
        .tick   (sec_tick),
        .any_en (any_en),
        .match  (set_req)
    );

    alarm_flag_ctl #(
        .DATA_W   (DATA_W),
        .FLAG_POS (FLAG_POS),
        .IE_POS   (IE_POS)
    ) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wdata   (reg_wdata),
        .set_req (set_req),
        .flag    (flag),
        .ie      (ie),
        .irq     (irq)
    );

    // Read mux: control word, one compare register, or zero.
    always_comb begin
        reg_rdata = '0;
        if (ctrl_sel) begin
            reg_rdata[FLAG_POS] = flag;
            reg_rdata[IE_POS]   = ie;
        end
        for (int i = 0; i < FIELD_CNT; i++) begin
            if (cmp_sel[i]) begin
                reg_rdata = cmp_regs[i];
            end
        end
    end

    assign irq_alarm = irq;

endmodule

// File: rtl/alarm_match_unit_chk.sv
// Module: alarm_match_unit_chk
// Property checker for the alarm flag and interrupt, bound to the top.
module alarm_match_unit_chk #(
    parameter int DATA_W   = 8,
    parameter int FLAG_POS = 0,
    parameter int IE_POS   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              ctrl_wr,
    input logic [DATA_W-1:0] wdata,
    input logic              set_req,
    input logic              any_en,
    input logic              flag,
    input logic              irq
);

    // R7: flag holds unless cleared by a zero write.
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !(ctrl_wr && !wdata[FLAG_POS]) |=> flag);

    // R5: no strobe, no new flag.
    p_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !flag && !tick |=> !flag);

    // R3: with no field enabled the flag cannot rise.
    p_no_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flag && !any_en |=> !flag);

    // R10: a match wins over a clearing write.
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> flag);

    // R8: a zero write with no match clears the flag.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !wdata[FLAG_POS] && !set_req |=> !flag);

    // R9: disabling the interrupt silences the output.
    p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !wdata[IE_POS] |=> !irq);

endmodule

bind alarm_match_unit alarm_match_unit_chk #(
    .DATA_W   (DATA_W),
    .FLAG_POS (FLAG_POS),
    .IE_POS   (IE_POS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sec_tick),
    .ctrl_wr (ctrl_wr),
    .wdata   (reg_wdata),
    .set_req (set_req),
    .any_en  (any_en),
    .flag    (flag),
    .irq     (irq_alarm)
);

// File: tb/alarm_match_unit_bench.sv
// Scoreboard bench: driver tasks push expected read results into a queue,
// a monitor pops and compares them one cycle later.
module alarm_match_unit_bench;

    typedef struct {
        logic [3:0] addr;
        logic [7:0] exp_data;
        logic       exp_irq;
        string      tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] t_sec = '0, t_min = '0, t_hour = '0, t_wday = '0, t_mday = '0, t_mon = '0;
    logic       tick = 1'b0;
    logic       wr = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;
    exp_item_t sb_q[$];

    always #5 clk = ~clk;

    alarm_match_unit u_alarm_match_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_sec   (t_sec),
        .cur_min   (t_min),
        .cur_hour  (t_hour),
        .cur_wday  (t_wday),
        .cur_mday  (t_mday),
        .cur_mon   (t_mon),
        .sec_tick  (tick),
        .reg_wr    (wr),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq_alarm (irq)
    );

    // Monitor: compare queued expectations just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                vectors++;
                if (rdata !== it.exp_data || irq !== it.exp_irq) begin
                    fails++;
                    $display("FAIL %s: addr %0d rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
                             it.tag, it.addr, rdata, irq, it.exp_data, it.exp_irq);
                end
            end
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; tick = 1'b0; addr = a; wdata = d;
        @(posedge clk); #1;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        wr = 1'b0; tick = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [7:0] d,
                             input logic i, input string tag);
        exp_item_t it;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0; addr = a;
        it.addr = a; it.exp_data = d; it.exp_irq = i; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #2;
    endtask

    task automatic set_time(input logic [6:0] s, input logic [6:0] mi, input logic [6:0] h,
                            input logic [6:0] wd, input logic [6:0] md, input logic [6:0] mo);
        t_sec = s; t_min = mi; t_hour = h; t_wday = wd; t_mday = md; t_mon = mo;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state of every register and the interrupt.
        for (int a = 8; a <= 14; a++) expect_rd(4'(a), 8'h00, 1'b0, "R1 reset");

        // R2: compare registers take and return full bytes.
        wr_reg(4'd8, 8'hB0);   // second 30, enabled
        wr_reg(4'd9, 8'h95);   // minute 15, enabled
        expect_rd(4'd8, 8'hB0, 1'b0, "R2 second readback");
        expect_rd(4'd9, 8'h95, 1'b0, "R2 minute readback");

        // R5: matching time without a strobe does nothing.
        set_time(7'h30, 7'h15, 7'h07, 7'h02, 7'h11, 7'h05);
        idle_cycle();
        expect_rd(4'd14, 8'h00, 1'b0, "R5 no tick");

        // R6: one enabled field off by one.
        set_time(7'h30, 7'h16, 7'h07, 7'h02, 7'h11, 7'h05);
        pulse_tick();
        expect_rd(4'd14, 8'h00, 1'b0, "R6 minute mismatch");

        // R4 and R9: match sets flag, irq stays low with enable off.
        set_time(7'h30, 7'h15, 7'h07, 7'h02, 7'h11, 7'h05);
        pulse_tick();
        expect_rd(4'd14, 8'h01, 1'b0, "R4 match sets flag");

        // R7 and R9: writing 1 to flag keeps it; enable raises irq.
        wr_reg(4'd14, 8'h09);
        expect_rd(4'd14, 8'h09, 1'b1, "R9 irq with enable");
        set_time(7'h31, 7'h15, 7'h07, 7'h02, 7'h11, 7'h05);
        pulse_tick();
        expect_rd(4'd14, 8'h09, 1'b1, "R7 sticky on mismatch");

        // R8: zero in flag bit clears it.
        wr_reg(4'd14, 8'h08);
        expect_rd(4'd14, 8'h08, 1'b0, "R8 clear flag");

        // R3: all registers zero, strobe never sets.
        for (int a = 8; a <= 13; a++) wr_reg(4'(a), 8'h00);
        set_time(7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00);
        pulse_tick();
        expect_rd(4'd14, 8'h08, 1'b0, "R3 nothing enabled");

        // R3 and R4: month only; a disabled weekday value is ignored.
        wr_reg(4'd13, 8'h92);  // month 12, enabled
        wr_reg(4'd11, 8'h05);  // weekday 5, not enabled
        set_time(7'h45, 7'h59, 7'h23, 7'h03, 7'h31, 7'h12);
        pulse_tick();
        expect_rd(4'd14, 8'h09, 1'b1, "R4 month 12 match, R3 weekday ignored");
        expect_rd(4'd11, 8'h05, 1'b1, "R2 weekday readback");

        // R10: clearing write and matching strobe together.
        wr_reg(4'd14, 8'h08);
        expect_rd(4'd14, 8'h08, 1'b0, "R8 clear before contention");
        @(negedge clk);
        wr = 1'b1; tick = 1'b1; addr = 4'd14; wdata = 8'h08;
        @(posedge clk); #1;
        expect_rd(4'd14, 8'h09, 1'b1, "R10 set wins over clear");

        // R9: disabling enable drops irq and clears flag.
        wr_reg(4'd14, 8'h00);
        expect_rd(4'd14, 8'h00, 1'b0, "R9 enable off");

        // R11: writes outside the map are ignored.
        wr_reg(4'd3, 8'hFF);
        wr_reg(4'd15, 8'hFF);
        wr_reg(4'd7, 8'hFF);
        expect_rd(4'd3, 8'h00, 1'b0, "R11 addr 3 reads zero");
        expect_rd(4'd15, 8'h00, 1'b0, "R11 addr 15 reads zero");
        expect_rd(4'd13, 8'h92, 1'b0, "R11 month untouched");
        expect_rd(4'd14, 8'h00, 1'b0, "R11 control untouched");

        // R4: all six fields enabled.
        wr_reg(4'd8, 8'h80 | 8'h05);
        wr_reg(4'd9, 8'h80 | 8'h30);
        wr_reg(4'd10, 8'h80 | 8'h07);
        wr_reg(4'd11, 8'h80 | 8'h01);
        wr_reg(4'd12, 8'h80 | 8'h15);
        wr_reg(4'd13, 8'h80 | 8'h06);
        set_time(7'h05, 7'h30, 7'h07, 7'h01, 7'h15, 7'h07);
        pulse_tick();
        expect_rd(4'd14, 8'h00, 1'b0, "R6 month mismatch of six");
        set_time(7'h05, 7'h30, 7'h07, 7'h01, 7'h15, 7'h06);
        pulse_tick();
        expect_rd(4'd14, 8'h01, 1'b0, "R4 six-field match");

        idle_cycle();
        idle_cycle();
        done = 1'b1;
        finish_run();
    end

endmodule